// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block drives one auxiliary-channel transaction through repeated attempts until the transaction passes or one of its retry budgets is used up. A transaction is opened with a one-cycle `start`. On that cycle the block captures the direction, the requested read length and a defer delay in milliseconds. For each attempt it raises `att_start` for one cycle. It then waits for the channel model to return a result on `res_valid`. When a result reports a successful channel, that result also carries a reply code and the number of data bytes returned.

Each outcome is classified. The outcome updates a set of per-cause counters. The block then decides whether to pass, to fail, or to start another attempt. A retry may be preceded by a wait, which is measured in 1 µs ticks from `tick_us`. The transaction ends with a one-cycle `done`, and `pass` gives the verdict and holds it until the next `done`. A `start` that arrives while a transaction is running is ignored.

Top module: `aux_retry_ctrl`

## Requirements
- R1: At most `MAX_ATT` attempts are issued per transaction (default 7). If a result would call for another retry once that many attempts have been issued, the transaction ends with `pass`=0 and no further `att_start` appears.
- R2: The transaction ends with `pass`=1 in either of two cases: a write, or a read whose `rx_bytes` equals the requested length. In both cases the result must be `res_code`=0 (channel ok) with `reply_code`=0 (acknowledge).
- R3: A read that receives an acknowledge (`res_code`=0, `reply_code`=0) with `rx_bytes` different from the requested length is a short read. The next attempt follows 300 ticks later. The seventh short read in a transaction fails it.
- R4: The following replies share one defer counter, and the seventh count fails the transaction:
  - a native defer (`reply_code`=2)
  - an I2C-over-AUX defer (`reply_code`=4)
  - an I2C-over-AUX NACK (`reply_code`=3)
  The two defer codes also mark the transaction as having seen a defer. After either defer code the next attempt waits `defer_ms`×1000 ticks, or starts at once when `defer_ms` is 0. After an I2C-over-AUX NACK the next attempt starts at once.
- R5: An I2C defer (`reply_code`=5) clears the shared defer counter and counts in its own counter. The seventh I2C defer fails the transaction. The retry after an I2C defer starts without a wait.
- R6: An invalid-reply result (`res_code`=1) counts toward a limit of 2. Reaching the limit fails the transaction. Otherwise the next attempt starts 400 ticks later.
- R7: A timeout result (`res_code`=2) is handled in one of two ways:
  - Before any defer has been seen in the transaction, it counts toward a limit of 3 and the retry starts without a wait.
  - After a defer has been seen, it is treated as a defer under R4, including the defer wait.
- R8: Every result with `res_code`=0 clears the timeout counter and the invalid-reply counter.
- R9: With `res_code`=0, a native NACK (`reply_code`=1) fails the transaction at once, and so does any reply code above 5.
- R10: A hot-plug disconnect (`res_code`=3) fails the transaction at once. So do an arbitration loss (`res_code`=4) and any `res_code` above 4.
- R11: Output timing is fixed:
  - The first `att_start` comes in the cycle after `start` is sampled.
  - A retry without a wait raises `att_start` in the cycle after the result is sampled.
  - A wait of N ticks, with one tick every cycle, delays that `att_start` by N cycles.
  - `done` is high for one cycle, in the cycle after the final result is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a transaction when the block is idle |
| is_write | input | 1 | Transaction direction, 1 = write; captured at start |
| req_len | input | LEN_W | Requested byte count; captured at start |
| defer_ms | input | DMS_W | Wait after a defer, in milliseconds; captured at start |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| att_start | output | 1 | One-cycle pulse that launches a channel attempt |
| res_valid | input | 1 | Attempt result is present |
| res_code | input | 3 | Channel outcome: 0 ok, 1 invalid reply, 2 timeout, 3 disconnect, 4 arbitration loss |
| reply_code | input | 3 | Reply on an ok channel: 0 ACK, 1 NACK, 2 defer, 3 I2C-over-AUX NACK, 4 I2C-over-AUX defer, 5 I2C defer |
| rx_bytes | input | LEN_W | Data bytes returned with the reply |
| done | output | 1 | One-cycle end-of-transaction pulse |
| pass | output | 1 | Verdict of the last transaction |

## Verification
The bench drives scripted result sequences and checks two things: the gap before every attempt, and the final verdict. Single-result sequences show that each terminal code ends the transaction at once. Repeated runs of one cause show that each counter stops at its own limit and not at a neighbouring one. Mixed runs separate the counter interactions:
- a successful result between two invalid replies or two timeouts clears the earlier count;
- timeouts after a defer take the defer wait and escape the timeout limit;
- an I2C defer restores the shared defer budget.

Some runs are built so that no counter reaches its limit. These leave attempt exhaustion as the only way to fail.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;

   typedef enum logic [2:0] {
      CH_OK       = 3'd0,
      CH_INVALID  = 3'd1,
      CH_TIMEOUT  = 3'd2,
      CH_DISCON   = 3'd3,
      CH_ARB_LOST = 3'd4
   } ch_res_e;

   typedef enum logic [2:0] {
      RP_ACK           = 3'd0,
      RP_NACK          = 3'd1,
      RP_DEFER         = 3'd2,
      RP_I2C_NACK      = 3'd3,
      RP_I2C_AUX_DEFER = 3'd4,
      RP_I2C_DEFER     = 3'd5
   } rep_e;

   typedef enum logic [1:0] {V_PASS, V_FAIL, V_RETRY} verdict_e;

   typedef enum logic [1:0] {W_NONE, W_SHORT, W_INVAL, W_DEFER} wsel_e;

   typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_PAUSE} st_e;

   typedef struct packed {
      logic clr_tmo;
      logic clr_inv;
      logic clr_def;
      logic inc_short;
      logic inc_def;
      logic inc_i2c;
      logic inc_inv;
      logic inc_tmo;
      logic set_seen;
   } upd_t;

endpackage

// File: rtl/aux_rty_budget.sv
module aux_rty_budget #(
   parameter int LIM = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last,
   output logic spent
);
   localparam int CW = $clog2(LIM + 1);

   generate
      if (LIM < 1) begin : g_bad_lim
         $error("aux_rty_budget: LIM must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (clr)                        cnt_q <= '0;
      else if (inc && cnt_q != CW'(LIM))   cnt_q <= cnt_q + 1'b1;
   end

   assign last  = (cnt_q == CW'(LIM - 1));
   assign spent = (cnt_q == CW'(LIM));
endmodule

// File: rtl/aux_rty_timer.sv
module aux_rty_timer #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         tick,
   output logic         expire
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (load)                 cnt_q <= load_val;
      else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expire = !load && tick && (cnt_q == W'(1));
endmodule

// File: rtl/aux_rty_judge.sv
module aux_rty_judge
   import aux_retry_pkg::*;
(
   input  logic [2:0] res,
   input  logic [2:0] reply,
   input  logic       short_rd,
   input  logic       seen,
   input  logic       last_short,
   input  logic       last_def,
   input  logic       last_i2c,
   input  logic       last_inv,
   input  logic       last_tmo,
   output verdict_e   verdict,
   output wsel_e      wsel,
   output upd_t       upd
);
   always_comb begin
      verdict = V_FAIL;
      wsel    = W_NONE;
      upd     = '0;
      case (res)
         CH_OK: begin
            upd.clr_tmo = 1'b1;
            upd.clr_inv = 1'b1;
            case (reply)
               RP_ACK: begin
                  if (short_rd) begin
                     upd.inc_short = 1'b1;
                     verdict = last_short ? V_FAIL : V_RETRY;
                     wsel    = W_SHORT;
                  end else begin
                     verdict = V_PASS;
                  end
               end
               RP_DEFER, RP_I2C_AUX_DEFER: begin
                  upd.set_seen = 1'b1;
                  upd.inc_def  = 1'b1;
                  verdict = last_def ? V_FAIL : V_RETRY;
                  wsel    = W_DEFER;
               end
               RP_I2C_NACK: begin
                  upd.inc_def = 1'b1;
                  verdict = last_def ? V_FAIL : V_RETRY;
               end
               RP_I2C_DEFER: begin
                  upd.clr_def = 1'b1;
                  upd.inc_i2c = 1'b1;
                  verdict = last_i2c ? V_FAIL : V_RETRY;
               end
               default: verdict = V_FAIL;
            endcase
         end
         CH_INVALID: begin
            upd.inc_inv = 1'b1;
            verdict = last_inv ? V_FAIL : V_RETRY;
            wsel    = W_INVAL;
         end
         CH_TIMEOUT: begin
            if (seen) begin
               upd.inc_def = 1'b1;
               verdict = last_def ? V_FAIL : V_RETRY;
               wsel    = W_DEFER;
            end else begin
               upd.inc_tmo = 1'b1;
               verdict = last_tmo ? V_FAIL : V_RETRY;
            end
         end
         default: verdict = V_FAIL;
      endcase
   end
endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
   import aux_retry_pkg::*;
#(
   parameter int MAX_ATT       = 7,
   parameter int SHORT_LIM     = 7,
   parameter int DEFER_LIM     = 7,
   parameter int I2C_DEFER_LIM = 7,
   parameter int INVAL_LIM     = 2,
   parameter int TMO_LIM       = 3,
   parameter int SHORT_WAIT    = 300,
   parameter int INVAL_WAIT    = 400,
   parameter int TICKS_PER_MS  = 1000,
   parameter int LEN_W         = 5,
   parameter int DMS_W         = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_write,
   input  logic [LEN_W-1:0] req_len,
   input  logic [DMS_W-1:0] defer_ms,
   input  logic             tick_us,
   output logic             att_start,
   input  logic             res_valid,
   input  logic [2:0]       res_code,
   input  logic [2:0]       reply_code,
   input  logic [LEN_W-1:0] rx_bytes,
   output logic             done,
   output logic             pass
);
   localparam int MAX_DEF_T = ((1 << DMS_W) - 1) * TICKS_PER_MS;
   localparam int MAX_FIX_T = (SHORT_WAIT > INVAL_WAIT) ? SHORT_WAIT : INVAL_WAIT;
   localparam int MAX_T     = (MAX_DEF_T > MAX_FIX_T) ? MAX_DEF_T : MAX_FIX_T;
   localparam int WT_W      = $clog2(MAX_T + 1);
   localparam bit TPM_POW2  = ((TICKS_PER_MS & (TICKS_PER_MS - 1)) == 0);
   localparam int TPM_SH    = $clog2(TICKS_PER_MS);

   generate
      if (MAX_ATT < 1 || TICKS_PER_MS < 1 || LEN_W < 1 || DMS_W < 1) begin : g_bad_cfg
         $error("aux_retry_ctrl: counts and widths must be positive");
      end
   endgenerate

   st_e              st_q, st_d;
   logic             wr_q, seen_q, done_q, pass_q;
   logic [LEN_W-1:0] len_q;
   logic [DMS_W-1:0] dms_q;
   logic [WT_W-1:0]  defer_ticks, wait_val;

   verdict_e verdict;
   wsel_e    wsel;
   upd_t     upd;
   logic     last_short, last_def, last_i2c, last_inv, last_tmo;
   logic     att_spent, att_last, expire;

   wire begin_txn = (st_q == ST_IDLE) && start;
   wire judge_en  = (st_q == ST_WAIT) && res_valid;
   wire retry_ok  = (verdict == V_RETRY) && !att_spent;
   wire finish    = judge_en && !retry_ok;
   wire short_rd  = !wr_q && (rx_bytes != len_q);

   // defer delay in ticks: shift when the ticks-per-ms factor is a power of two
   generate
      if (TPM_POW2) begin : g_dly_shift
         assign defer_ticks = WT_W'(dms_q) << TPM_SH;
      end else begin : g_dly_mul
         assign defer_ticks = WT_W'(dms_q) * WT_W'(TICKS_PER_MS);
      end
   endgenerate

   always_comb begin
      case (wsel)
         W_SHORT: wait_val = WT_W'(SHORT_WAIT);
         W_INVAL: wait_val = WT_W'(INVAL_WAIT);
         W_DEFER: wait_val = defer_ticks;
         default: wait_val = '0;
      endcase
   end

   aux_rty_judge u_judge (
      .res(res_code), .reply(reply_code), .short_rd(short_rd), .seen(seen_q),
      .last_short(last_short), .last_def(last_def), .last_i2c(last_i2c),
      .last_inv(last_inv), .last_tmo(last_tmo),
      .verdict(verdict), .wsel(wsel), .upd(upd)
   );

   aux_rty_budget #(.LIM(MAX_ATT)) u_att (
      .clk(clk), .rst_n(rst_n), .clr(begin_txn), .inc(st_q == ST_ISSUE),
      .last(att_last), .spent(att_spent));

   aux_rty_budget #(.LIM(SHORT_LIM)) u_short (
      .clk(clk), .rst_n(rst_n), .clr(begin_txn), .inc(judge_en && upd.inc_short),
      .last(last_short), .spent());

   aux_rty_budget #(.LIM(DEFER_LIM)) u_def (
      .clk(clk), .rst_n(rst_n), .clr(begin_txn || (judge_en && upd.clr_def)),
      .inc(judge_en && upd.inc_def), .last(last_def), .spent());

   aux_rty_budget #(.LIM(I2C_DEFER_LIM)) u_i2c (
      .clk(clk), .rst_n(rst_n), .clr(begin_txn), .inc(judge_en && upd.inc_i2c),
      .last(last_i2c), .spent());

   aux_rty_budget #(.LIM(INVAL_LIM)) u_inv (
      .clk(clk), .rst_n(rst_n), .clr(begin_txn || (judge_en && upd.clr_inv)),
      .inc(judge_en && upd.inc_inv), .last(last_inv), .spent());

   aux_rty_budget #(.LIM(TMO_LIM)) u_tmo (
      .clk(clk), .rst_n(rst_n), .clr(begin_txn || (judge_en && upd.clr_tmo)),
      .inc(judge_en && upd.inc_tmo), .last(last_tmo), .spent());

   aux_rty_timer #(.W(WT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(judge_en && st_d == ST_PAUSE),
      .load_val(wait_val), .tick(tick_us), .expire(expire));

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:  if (start) st_d = ST_ISSUE;
         ST_ISSUE: st_d = ST_WAIT;
         ST_WAIT:
            if (res_valid) begin
               if (!retry_ok)             st_d = ST_IDLE;
               else if (wait_val == '0)   st_d = ST_ISSUE;
               else                       st_d = ST_PAUSE;
            end
         ST_PAUSE: if (expire) st_d = ST_ISSUE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         wr_q   <= 1'b0;
         len_q  <= '0;
         dms_q  <= '0;
         seen_q <= 1'b0;
         done_q <= 1'b0;
         pass_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= finish;
         if (finish) pass_q <= (verdict == V_PASS);
         if (begin_txn) begin
            wr_q   <= is_write;
            len_q  <= req_len;
            dms_q  <= defer_ms;
            seen_q <= 1'b0;
         end else if (judge_en && upd.set_seen) begin
            seen_q <= 1'b1;
         end
      end
   end

   assign att_start = (st_q == ST_ISSUE);
   assign done      = done_q;
   assign pass      = pass_q;

   logic unused_ok;
   assign unused_ok = att_last;
endmodule

// File: rtl/aux_retry_chk.sv
module aux_retry_chk #(
   parameter int MAX_ATT = 7
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       att_start,
   input logic       res_valid,
   input logic [2:0] res_code,
   input logic [2:0] reply_code,
   input logic       done,
   input logic       pass
);
   logic       busy_q, waiting_q;
   logic [7:0] att_cnt_q;

   wire accept = start && (!busy_q || done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         waiting_q <= 1'b0;
         att_cnt_q <= '0;
      end else begin
         if (accept)       busy_q <= 1'b1;
         else if (done)    busy_q <= 1'b0;
         if (att_start)      waiting_q <= 1'b1;
         else if (res_valid) waiting_q <= 1'b0;
         if (accept)                              att_cnt_q <= '0;
         else if (att_start && att_cnt_q != 8'hFF) att_cnt_q <= att_cnt_q + 1'b1;
      end
   end

   a_r1_att_cap: assert property (@(posedge clk) disable iff (!rst_n)
      att_cnt_q <= 8'(MAX_ATT));

   a_r10_term_result: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting_q && res_valid && res_code >= 3'd3) |=> (done && !pass));

   a_r9_nack_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting_q && res_valid && res_code == 3'd0 && reply_code == 3'd1) |=> (done && !pass));

   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(res_valid && waiting_q));

   a_r11_att_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      att_start |=> !att_start);
endmodule

bind aux_retry_ctrl aux_retry_chk #(.MAX_ATT(MAX_ATT)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .att_start(att_start),
   .res_valid(res_valid), .res_code(res_code), .reply_code(reply_code),
   .done(done), .pass(pass));

// File: tb/aux_retry_ctrl_tb.sv
module aux_retry_ctrl_tb_top;
   localparam int MAXA = 10;
   localparam int SW   = 300;
   localparam int IW   = 400;
   localparam int TPM  = 1000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0, is_write = 1'b0, tick_us = 1'b1;
   logic [4:0] req_len = '0, rx_bytes = '0;
   logic [3:0] defer_ms = '0;
   logic       res_valid = 1'b0;
   logic [2:0] res_code = '0, reply_code = '0;
   logic       att_start, done, pass;

   int n_chk = 0, n_bad = 0;
   logic [2:0] q_res [16];
   logic [2:0] q_rep [16];
   logic [4:0] q_by  [16];
   int         q_gap [16];
   int         q_n = 0;

   always #4 clk = ~clk;

   aux_retry_ctrl #(.MAX_ATT(MAXA)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
      .req_len(req_len), .defer_ms(defer_ms), .tick_us(tick_us),
      .att_start(att_start), .res_valid(res_valid), .res_code(res_code),
      .reply_code(reply_code), .rx_bytes(rx_bytes), .done(done), .pass(pass));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic add(input logic [2:0] r, input logic [2:0] rp,
                      input logic [4:0] by, input int gap);
      q_res[q_n] = r; q_rep[q_n] = rp; q_by[q_n] = by; q_gap[q_n] = gap;
      q_n++;
   endtask

   task automatic run(input string req, input bit wr, input logic [4:0] len,
                      input logic [3:0] dms, input bit exp_pass);
      int quiet;
      @(negedge clk);
      is_write = wr; req_len = len; defer_ms = dms; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < q_n; i++) begin
         int cnt = 0;
         bit early = 0;
         while (!att_start && cnt < 20000) begin
            if (done) early = 1;
            @(negedge clk);
            cnt++;
         end
         check(cnt == q_gap[i], req, $sformatf("gap before attempt %0d", i + 1), cnt, q_gap[i]);
         check(!early, req, $sformatf("early done before attempt %0d", i + 1), int'(early), 0);
         @(negedge clk);
         res_valid = 1'b1; res_code = q_res[i]; reply_code = q_rep[i]; rx_bytes = q_by[i];
         @(negedge clk);
         res_valid = 1'b0;
      end
      check(done == 1'b1, req, "done after final result", int'(done), 1);
      check(pass == exp_pass, req, "verdict", int'(pass), int'(exp_pass));
      quiet = 0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (att_start || done) quiet++;
      end
      check(quiet == 0, req, "activity after done", quiet, 0);
      q_n = 0;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!att_start && !done && !pass, "R11", "reset outputs",
            int'({att_start, done, pass}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2: write acknowledged, read with full length
      add(0, 0, 0, 0);                        run("R2", 1'b1, 5'd4, 4'd0, 1'b1);
      add(0, 0, 4, 0);                        run("R2", 1'b0, 5'd4, 4'd0, 1'b1);
      // R3: one short read then full
      add(0, 0, 2, 0); add(0, 0, 4, SW);      run("R3", 1'b0, 5'd4, 4'd0, 1'b1);
      // R3: seven short reads fail on the seventh
      add(0, 0, 1, 0);
      for (int i = 1; i < 7; i++) add(0, 0, 1, SW);
      run("R3", 1'b0, 5'd4, 4'd0, 1'b0);
      // R9: native NACK and unknown reply
      add(0, 1, 0, 0);                        run("R9", 1'b1, 5'd2, 4'd0, 1'b0);
      add(0, 7, 0, 0);                        run("R9", 1'b1, 5'd2, 4'd0, 1'b0);
      // R10: disconnect, arbitration loss, unknown result
      add(3, 0, 0, 0);                        run("R10", 1'b1, 5'd2, 4'd0, 1'b0);
      add(4, 0, 0, 0);                        run("R10", 1'b1, 5'd2, 4'd0, 1'b0);
      add(6, 0, 0, 0);                        run("R10", 1'b0, 5'd2, 4'd0, 1'b0);
      // R6: two invalid replies
      add(1, 0, 0, 0); add(1, 0, 0, IW);      run("R6", 1'b1, 5'd2, 4'd0, 1'b0);
      // R8: ok result between invalid replies clears the count
      add(1, 0, 0, 0); add(0, 3, 0, IW); add(1, 0, 0, 0); add(0, 0, 0, IW);
      run("R8", 1'b1, 5'd2, 4'd0, 1'b1);
      // R7: three timeouts with no defer
      add(2, 0, 0, 0); add(2, 0, 0, 0); add(2, 0, 0, 0);
      run("R7", 1'b1, 5'd2, 4'd0, 1'b0);
      // R8: ok result between timeouts clears the count
      add(2, 0, 0, 0); add(2, 0, 0, 0); add(0, 3, 0, 0); add(2, 0, 0, 0);
      add(2, 0, 0, 0); add(0, 0, 0, 0);
      run("R8", 1'b1, 5'd2, 4'd0, 1'b1);
      // R7: timeouts after a defer are defers, with the defer wait
      add(0, 2, 0, 0);
      for (int i = 0; i < 3; i++) add(2, 0, 0, 1 * TPM);
      add(0, 0, 0, 1 * TPM);
      run("R7", 1'b1, 5'd2, 4'd1, 1'b1);
      // R4: I2C-over-AUX defer with 2 ms delay
      add(0, 4, 0, 0); add(0, 0, 0, 2 * TPM); run("R4", 1'b1, 5'd2, 4'd2, 1'b1);
      // R4: seven native defers, zero delay
      for (int i = 0; i < 7; i++) add(0, 2, 0, 0);
      run("R4", 1'b1, 5'd2, 4'd0, 1'b0);
      // R4: mixed codes share one counter
      add(0, 4, 0, 0); add(0, 3, 0, 0); add(0, 2, 0, 0); add(0, 3, 0, 0);
      add(0, 4, 0, 0); add(0, 3, 0, 0); add(0, 2, 0, 0);
      run("R4", 1'b1, 5'd2, 4'd0, 1'b0);
      // R5: I2C defer restores the shared defer budget
      for (int i = 0; i < 6; i++) add(0, 2, 0, 0);
      add(0, 5, 0, 0); add(0, 2, 0, 0); add(0, 2, 0, 0); add(0, 0, 0, 0);
      run("R5", 1'b1, 5'd2, 4'd0, 1'b1);
      // R5: seven I2C defers
      for (int i = 0; i < 7; i++) add(0, 5, 0, 0);
      run("R5", 1'b1, 5'd2, 4'd0, 1'b0);
      // R1: attempt cap with no counter at its limit
      for (int i = 0; i < 5; i++) add(0, 2, 0, 0);
      add(0, 0, 1, 0);
      for (int i = 0; i < 4; i++) add(0, 0, 1, SW);
      run("R1", 1'b0, 5'd4, 4'd0, 1'b0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule